// File: doc/BRIEF.md
# Dual-Half Asynchronous SRAM Controller

This block sits between a synchronous host and an asynchronous static RAM built from two 16-bit halves. The halves share one row address bus and one output enable. Each half has its own active-low chip select and write strobe. The host holds a request (`req_i`, `we_i`, `addr_i`, `wdata_i`, `half_en_i`, `mode16_i`) until the controller pulses `ready_o`. On that pulse, read data is valid on `rdata_o`. Every strobe width and every wait is a whole number of clock cycles. These counts are derived at elaboration from the clock period and the speed grade (20, 25 or 35 ns), so one RTL body covers every grade.

In 32-bit mode the two halves act as one wide word. The half-enable bits pick which halves are strobed. In 16-bit mode the memory looks like twice as many 16-bit words. The top address bit picks the half, and the low 16 bits of the host data travel on that half's lanes.

A read leaves the memory driving the data bus for a while after output enable rises. The controller counts those cycles before it turns its own data drivers on. A write that follows a read is therefore delayed only as long as the bus needs.

Top module: `asram_pair_ctrl`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after it rises, both chip selects, both write strobes and the output enable are high, `mem_dq_oe_o` is low and `ready_o` is low.
- R2: A 32-bit read does the following:
  - It pulls the chip select low for each half whose `half_en_i` bit is set (bit 0 is lanes 15:0, bit 1 is lanes 31:16).
  - It holds output enable low and the write strobes high for RD_CYC = ceil(grade ns / clock period) cycles.
  - It samples the data bus in the last of those cycles.
  - It raises `ready_o` for one cycle, RD_CYC+1 cycles after the request is first seen. In that cycle `rdata_o` carries the sampled lanes, and the lanes of unselected halves are zero.
- R3: A write on a free bus does the following:
  - It holds chip select and write strobe low on the selected halves, with `mem_dq_oe_o` high, for WLOW = max(ceil(write pulse ns / period), RD_CYC-1) cycles. The write pulse is 17, 20 or 25 ns for grades 20, 25 or 35.
  - It then spends one cycle with all strobes high.
  - It raises `ready_o` WLOW+2 cycles after the request.
  - No write strobe is ever low on a half whose chip select is high.
- R4: Output enable is never low while `mem_dq_oe_o` is high or while any write strobe is low. The controller never drives the data bus during a read.
- R5: In 16-bit mode, address bit 18 selects the half (0 is lower, 1 is upper), and `half_en_i` is ignored.
  - A write places `wdata_i[15:0]` on the chosen half's lanes and strobes only that half.
  - A read returns the chosen half in `rdata_o[15:0]` with `rdata_o[31:16]` zero.
- R6: The controller does not drive the data bus within TURN = ceil(output-disable ns / period) cycles after the last cycle with output enable low. The output-disable time is 12, 15 or 20 ns by grade. If a write is requested d cycles after a read's ready cycle, its ready comes max(d+1, TURN) − d + WLOW + 1 cycles after the request.
- R7: Address and write data stay stable for every cycle a write strobe is low, and for the cycle after the strobe rises.
- R8: With no request pending, both chip selects and the output enable are high and the data drivers are off.
- R9: A request held or raised in the cycle `ready_o` is high is taken at the next clock edge. Back-to-back reads therefore each complete in RD_CYC+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| mode16_i | input | 1 | 1 = 16-bit addressing, 0 = 32-bit |
| addr_i | input | 19 | Row address; bit 18 is the half select in 16-bit mode |
| half_en_i | input | 2 | Half enables for 32-bit mode |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with `ready_o` after a read |
| mem_addr_o | output | 18 | Memory row address |
| mem_cs_no | output | 2 | Chip selects per half, active low |
| mem_we_no | output | 2 | Write strobes per half, active low |
| mem_oe_no | output | 1 | Shared output enable, active low |
| mem_dq_o | output | 32 | Data toward the memory |
| mem_dq_oe_o | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | 32 | Data from the memory |

## Verification
Two functions can collide in one cycle: the end of a read, when the memory is still releasing the bus, and a write that wants to turn the controller's drivers on. The bench issues writes in the very cycle a read reports ready, and also a few cycles later. Its memory model keeps the bus driven for the output-disable window and flags any cycle in which both sides drive. Each such write's completion latency is compared with the value the requirement formula gives for that gap.

// File: rtl/asram_pkg.sv
package asram_pkg;

  localparam int N_HALF = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_WHOLD
  } seq_state_e;

  function automatic int cdiv(int a, int b);
    return (a + b - 1) / b;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // cycle time and address access time equal the grade
  function automatic int cyc_ps(int g);
    return g * 1000;
  endfunction

  function automatic int wpulse_ps(int g);
    case (g)
      20:      return 17000;
      35:      return 25000;
      default: return 20000;
    endcase
  endfunction

  function automatic int release_ps(int g);
    case (g)
      20:      return 12000;
      35:      return 20000;
      default: return 15000;
    endcase
  endfunction

endpackage

// File: rtl/asram_lane_map.sv
module asram_lane_map #(
  parameter int ROW_W  = 18,
  parameter int HALF_W = 16
) (
  input  logic                mode16_i,
  input  logic [ROW_W:0]      addr_i,
  input  logic [1:0]          half_en_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  output logic [1:0]          sel_o,
  output logic [ROW_W-1:0]    row_o,
  output logic [2*HALF_W-1:0] lane_o
);

  always_comb begin
    row_o = addr_i[ROW_W-1:0];
    if (mode16_i) begin
      sel_o  = addr_i[ROW_W] ? 2'b10 : 2'b01;
      lane_o = {2{wdata_i[HALF_W-1:0]}};
    end else begin
      sel_o  = half_en_i;
      lane_o = wdata_i;
    end
  end

endmodule

// File: rtl/asram_bus_guard.sv
module asram_bus_guard #(
  parameter int TURN_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_act_i,
  output logic free_next_o
);

  localparam int CW = $clog2(TURN_CYC + 1);

  logic [CW-1:0] rel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rel_q <= '0;
    else if (rd_act_i)     rel_q <= CW'(TURN_CYC);
    else if (rel_q != '0)  rel_q <= rel_q - 1'b1;
  end

  // look one cycle ahead: driver may start in the next cycle
  assign free_next_o = !rd_act_i && (rel_q <= CW'(1));

endmodule

// File: rtl/asram_half_lane.sv
module asram_half_lane #(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rd_act_i,
  input  logic              wr_act_i,
  input  logic              cap_i,
  input  logic [HALF_W-1:0] dq_i,
  output logic              cs_no,
  output logic              we_no,
  output logic [HALF_W-1:0] rdata_o
);

  assign cs_no = !(sel_i && (rd_act_i || wr_act_i));
  assign we_no = !(sel_i && wr_act_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= sel_i ? dq_i : '0;
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int ROW_W    = 18,
  parameter int HALF_W   = 16,
  parameter int RD_CYC   = 7,
  parameter int WLOW_CYC = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                mode16_i,
  input  logic [1:0]          sel_i,
  input  logic [ROW_W-1:0]    row_i,
  input  logic [2*HALF_W-1:0] lane_i,
  input  logic                free_next_i,
  output logic                rd_act_o,
  output logic                wr_act_o,
  output logic                drv_o,
  output logic                cap_o,
  output logic                ready_o,
  output logic [1:0]          sel_o,
  output logic [ROW_W-1:0]    row_o,
  output logic [2*HALF_W-1:0] lane_o,
  output logic                mode16_o
);

  localparam int CW = $clog2(imax(RD_CYC, WLOW_CYC) + 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      ready_o  <= 1'b0;
      sel_o    <= '0;
      row_o    <= '0;
      lane_o   <= '0;
      mode16_o <= 1'b0;
    end else begin
      ready_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            sel_o    <= sel_i;
            row_o    <= row_i;
            lane_o   <= lane_i;
            mode16_o <= mode16_i;
            if (!we_i) begin
              state_q <= ST_RD;
              cnt_q   <= CW'(RD_CYC - 1);
            end else if (free_next_i) begin
              state_q <= ST_WR;
              cnt_q   <= CW'(WLOW_CYC - 1);
            end else begin
              state_q <= ST_WAIT;
            end
          end
        end
        ST_RD: begin
          if (cnt_q == '0) begin
            state_q <= ST_IDLE;
            ready_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_WAIT: begin
          if (free_next_i) begin
            state_q <= ST_WR;
            cnt_q   <= CW'(WLOW_CYC - 1);
          end
        end
        ST_WR: begin
          if (cnt_q == '0) state_q <= ST_WHOLD;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        ST_WHOLD: begin
          state_q <= ST_IDLE;
          ready_o <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_act_o = (state_q == ST_RD);
  assign wr_act_o = (state_q == ST_WR);
  assign drv_o    = (state_q == ST_WR) || (state_q == ST_WHOLD);
  assign cap_o    = (state_q == ST_RD) && (cnt_q == '0);

endmodule

// File: rtl/asram_pair_ctrl.sv
module asram_pair_ctrl
  import asram_pkg::*;
#(
  parameter int ROW_W    = 18,
  parameter int HALF_W   = 16,
  parameter int CLK_PS   = 4000,
  parameter int GRADE_NS = 25
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                mode16_i,
  input  logic [ROW_W:0]      addr_i,
  input  logic [1:0]          half_en_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  output logic                ready_o,
  output logic [2*HALF_W-1:0] rdata_o,
  output logic [ROW_W-1:0]    mem_addr_o,
  output logic [1:0]          mem_cs_no,
  output logic [1:0]          mem_we_no,
  output logic                mem_oe_no,
  output logic [2*HALF_W-1:0] mem_dq_o,
  output logic                mem_dq_oe_o,
  input  logic [2*HALF_W-1:0] mem_dq_i
);

  localparam int DW       = N_HALF * HALF_W;
  localparam int RD_CYC   = cdiv(cyc_ps(GRADE_NS), CLK_PS);
  localparam int WP_CYC   = cdiv(wpulse_ps(GRADE_NS), CLK_PS);
  localparam int WLOW_CYC = imax(WP_CYC, RD_CYC - 1);
  localparam int TURN_CYC = imax(1, cdiv(release_ps(GRADE_NS), CLK_PS));

  logic [1:0]       sel_d, sel_q;
  logic [ROW_W-1:0] row_d;
  logic [DW-1:0]    lane_d, lane_q;
  logic             rd_act, wr_act, drv, cap, free_next, mode16_q;
  logic [DW-1:0]    raw_rd;

  asram_lane_map #(.ROW_W(ROW_W), .HALF_W(HALF_W)) i_map (
    .mode16_i (mode16_i),
    .addr_i   (addr_i),
    .half_en_i(half_en_i),
    .wdata_i  (wdata_i),
    .sel_o    (sel_d),
    .row_o    (row_d),
    .lane_o   (lane_d)
  );

  asram_seq #(
    .ROW_W(ROW_W), .HALF_W(HALF_W), .RD_CYC(RD_CYC), .WLOW_CYC(WLOW_CYC)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .mode16_i   (mode16_i),
    .sel_i      (sel_d),
    .row_i      (row_d),
    .lane_i     (lane_d),
    .free_next_i(free_next),
    .rd_act_o   (rd_act),
    .wr_act_o   (wr_act),
    .drv_o      (drv),
    .cap_o      (cap),
    .ready_o    (ready_o),
    .sel_o      (sel_q),
    .row_o      (mem_addr_o),
    .lane_o     (lane_q),
    .mode16_o   (mode16_q)
  );

  asram_bus_guard #(.TURN_CYC(TURN_CYC)) i_guard (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_act_i   (rd_act),
    .free_next_o(free_next)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    asram_half_lane #(.HALF_W(HALF_W)) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (sel_q[h]),
      .rd_act_i(rd_act),
      .wr_act_i(wr_act),
      .cap_i   (cap),
      .dq_i    (mem_dq_i[h*HALF_W +: HALF_W]),
      .cs_no   (mem_cs_no[h]),
      .we_no   (mem_we_no[h]),
      .rdata_o (raw_rd[h*HALF_W +: HALF_W])
    );
  end

  assign mem_oe_no   = !rd_act;
  assign mem_dq_o    = lane_q;
  assign mem_dq_oe_o = drv;

  // unselected half captures zero, so OR folds the chosen half down
  assign rdata_o = mode16_q
                 ? {{HALF_W{1'b0}}, raw_rd[HALF_W-1:0] | raw_rd[DW-1:HALF_W]}
                 : raw_rd;

endmodule

// File: rtl/asram_pair_ctrl_chk.sv
module asram_pair_ctrl_chk #(
  parameter int ROW_W    = 18,
  parameter int TURN_CYC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ready_o,
  input logic [ROW_W-1:0] mem_addr_o,
  input logic [1:0]       mem_cs_no,
  input logic [1:0]       mem_we_no,
  input logic             mem_oe_no,
  input logic             mem_dq_oe_o
);

  localparam int GW = $clog2(TURN_CYC + 1) + 1;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     gap_q <= GW'(TURN_CYC);
    else if (!mem_oe_no)             gap_q <= '0;
    else if (gap_q < GW'(TURN_CYC))  gap_q <= gap_q + 1'b1;
  end

  a_r4_no_drive_in_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  a_r4_oe_off_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_no != 2'b11) |-> mem_oe_no);

  a_r3_we_within_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_no != 2'b11) |-> ((~mem_we_no & mem_cs_no) == 2'b00));

  a_r3_drive_under_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_no != 2'b11) |-> mem_dq_oe_o);

  a_r7_addr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(mem_we_no) != 2'b11) && (mem_we_no == 2'b11)) |-> $stable(mem_addr_o));

  a_r6_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (gap_q >= GW'(TURN_CYC)));

  a_r2_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

endmodule

bind asram_pair_ctrl asram_pair_ctrl_chk #(.ROW_W(ROW_W), .TURN_CYC(TURN_CYC)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ready_o    (ready_o),
  .mem_addr_o (mem_addr_o),
  .mem_cs_no  (mem_cs_no),
  .mem_we_no  (mem_we_no),
  .mem_oe_no  (mem_oe_no),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/test_asram_pair_ctrl.sv
`timescale 1ns/1ps
module test_asram_pair_ctrl;

  localparam int CLK_PS = 4000;
  localparam int GRADE  = 25;

  function automatic int b_cdiv(int a, int b); return (a + b - 1) / b; endfunction
  function automatic int b_max(int a, int b); return (a > b) ? a : b; endfunction
  function automatic int b_wp_ns(int g);
    if (g == 20) return 17; else if (g == 35) return 25; else return 20;
  endfunction
  function automatic int b_rel_ns(int g);
    if (g == 20) return 12; else if (g == 35) return 20; else return 15;
  endfunction

  localparam int RD_B   = b_cdiv(GRADE * 1000, CLK_PS);
  localparam int WPMIN  = b_cdiv(b_wp_ns(GRADE) * 1000, CLK_PS);
  localparam int WLOW_B = b_max(WPMIN, RD_B - 1);
  localparam int TURN_B = b_max(1, b_cdiv(b_rel_ns(GRADE) * 1000, CLK_PS));

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, mode16 = 1'b0;
  logic [18:0] addr = '0;
  logic [1:0]  half_en = '0;
  logic [31:0] wdata = '0;
  logic        ready_o;
  logic [31:0] rdata_o;
  logic [17:0] mem_addr;
  logic [1:0]  mem_cs_n, mem_we_n;
  logic        mem_oe_n, mem_dq_oe;
  logic [31:0] mem_dq_o;
  logic [31:0] mem_dq_i = '0;

  int checks = 0, errors = 0, cyc = 0;
  int last_rd_ready = 0;
  bit have_rd = 0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc++;

  asram_pair_ctrl i_asram_pair_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req), .we_i(we), .mode16_i(mode16),
    .addr_i(addr), .half_en_i(half_en), .wdata_i(wdata), .ready_o(ready_o),
    .rdata_o(rdata_o), .mem_addr_o(mem_addr), .mem_cs_no(mem_cs_n),
    .mem_we_no(mem_we_n), .mem_oe_no(mem_oe_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe_o(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  logic [15:0] dev_mem [int];
  logic [15:0] exp_mem [int];

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 263) ^ 16'h5A3C;
  endfunction
  function automatic logic [15:0] dev_rd(int i);
    return dev_mem.exists(i) ? dev_mem[i] : init_val(i);
  endfunction
  function automatic logic [15:0] exp_rd(int i);
    return exp_mem.exists(i) ? exp_mem[i] : init_val(i);
  endfunction

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // cycle-accurate memory model with protocol checks on every clock
  int   rcnt [2], hold [2], wcnt [2];
  logic prev_rd [2], prev_act [2], drv_mem [2];
  logic [17:0] prev_addr;
  logic [31:0] prev_dq;

  always @(negedge clk_i) begin
    if (!rst_ni) begin
      for (int h = 0; h < 2; h++) begin
        rcnt[h] = 0; hold[h] = 0; wcnt[h] = 0;
        prev_rd[h] = 0; prev_act[h] = 0; drv_mem[h] = 0;
      end
      prev_addr = '0; prev_dq = '0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        logic rd_on, wr_on;
        rd_on = !mem_cs_n[h] && !mem_oe_n && mem_we_n[h];
        wr_on = !mem_cs_n[h] && !mem_we_n[h];
        if (rd_on) begin
          rcnt[h] = (prev_rd[h] && mem_addr == prev_addr) ? rcnt[h] + 1 : 1;
          hold[h] = TURN_B;
          drv_mem[h] = 1'b1;
        end else begin
          rcnt[h] = 0;
          drv_mem[h] = (hold[h] > 0);
          if (hold[h] > 0) hold[h]--;
        end
        mem_dq_i[h*16 +: 16] = (rd_on && rcnt[h] >= RD_B)
                             ? dev_rd(int'(mem_addr) * 2 + h) : (16'hDEAD ^ 16'(h));
        if (wr_on) begin
          if (prev_act[h])
            check("R7 addr/data stable under write strobe", 64'({mem_addr, mem_dq_o[h*16 +: 16]}),
                  64'({prev_addr, prev_dq[h*16 +: 16]}));
          check("R3 driver on under write strobe", 64'(mem_dq_oe), 64'(1));
          wcnt[h] = prev_act[h] ? wcnt[h] + 1 : 1;
        end else if (prev_act[h]) begin
          check("R3 write pulse long enough", 64'(wcnt[h] >= WPMIN), 64'(1));
          check("R7 address hold after strobe", 64'(mem_addr), 64'(prev_addr));
          dev_mem[int'(prev_addr) * 2 + h] = prev_dq[h*16 +: 16];
          wcnt[h] = 0;
        end
        prev_rd[h] = rd_on;
        prev_act[h] = wr_on;
      end
      check("R6 no bus contention", 64'(mem_dq_oe && (drv_mem[0] || drv_mem[1])), 64'(0));
      check("R4 no drive with output enable low", 64'(mem_dq_oe && !mem_oe_n), 64'(0));
      prev_addr = mem_addr;
      prev_dq = mem_dq_o;
    end
  end

  task automatic check_idle(input string tag);
    check({tag, " chip selects"}, 64'(mem_cs_n), 64'(2'b11));
    check({tag, " write strobes"}, 64'(mem_we_n), 64'(2'b11));
    check({tag, " output enable"}, 64'(mem_oe_n), 64'(1));
    check({tag, " drive enable"}, 64'(mem_dq_oe), 64'(0));
  endtask

  task automatic do_op(input logic w, input logic m16, input logic [18:0] a,
                       input logic [1:0] he, input logic [31:0] wd, input string tag);
    int c0, lat, exp_lat, row, d;
    logic [31:0] exp_data;
    row = int'(a[17:0]);
    c0 = cyc;
    req = 1'b1; we = w; mode16 = m16; addr = a; half_en = he; wdata = wd;
    if (w) begin
      if (have_rd) begin
        d = c0 - last_rd_ready;
        exp_lat = b_max(d + 1, TURN_B) - d + WLOW_B + 1;
      end else begin
        exp_lat = WLOW_B + 2;
      end
      if (m16) exp_mem[row * 2 + int'(a[18])] = wd[15:0];
      else begin
        if (he[0]) exp_mem[row * 2]     = wd[15:0];
        if (he[1]) exp_mem[row * 2 + 1] = wd[31:16];
      end
      exp_data = '0;
    end else begin
      exp_lat = RD_B + 1;
      if (m16) exp_data = {16'h0, exp_rd(row * 2 + int'(a[18]))};
      else exp_data = {he[1] ? exp_rd(row * 2 + 1) : 16'h0, he[0] ? exp_rd(row * 2) : 16'h0};
    end
    lat = 0;
    do begin
      @(negedge clk_i);
      lat++;
    end while (!ready_o && lat < 2000);
    req = 1'b0;
    check({tag, " latency"}, 64'(lat), 64'(exp_lat));
    if (!w) begin
      check({tag, " read data"}, 64'(rdata_o), 64'(exp_data));
      last_rd_ready = cyc;
      have_rd = 1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check_idle("R1 in reset");
    check("R1 ready in reset", 64'(ready_o), 64'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_idle("R1 after reset");
    check("R1 ready after reset", 64'(ready_o), 64'(0));

    do_op(0, 0, 19'd5, 2'b11, '0, "R2 x32 read of untouched row");
    do_op(1, 0, 19'd5, 2'b11, 32'h1234_5678, "R6 write in read ready cycle");
    do_op(0, 0, 19'd5, 2'b11, '0, "R2 read back full word");
    do_op(0, 0, 19'd5, 2'b11, '0, "R9 back-to-back read");

    repeat (10) @(negedge clk_i);
    check_idle("R8 idle");
    do_op(1, 0, 19'd9, 2'b01, 32'hAAAA_BBBB, "R3 lower-half write on free bus");
    do_op(1, 0, 19'd12, 2'b10, 32'hCAFE_0000, "R3 upper-half write after write");
    do_op(0, 0, 19'd9, 2'b11, '0, "R2 read of partly written row");
    do_op(0, 0, 19'd9, 2'b10, '0, "R2 upper-only read, lower lanes zero");

    repeat (8) @(negedge clk_i);
    do_op(1, 1, {1'b1, 18'd9}, 2'b00, 32'h0000_C0DE, "R5 x16 write to upper half");
    do_op(0, 0, 19'd9, 2'b11, '0, "R5 x32 view of x16 write");
    do_op(0, 1, {1'b0, 18'd9}, 2'b11, '0, "R5 x16 read lower half");
    do_op(0, 1, {1'b1, 18'd9}, 2'b00, '0, "R5 x16 read upper, enables ignored");
    do_op(1, 1, {1'b0, 18'd12}, 2'b10, 32'hFFFF_7777, "R5 x16 lower write after read");
    do_op(0, 0, 19'd12, 2'b11, '0, "R5 lanes of row 12");

    do_op(0, 0, 19'd20, 2'b11, '0, "R2 read before delayed write");
    repeat (2) @(negedge clk_i);
    do_op(1, 0, 19'd20, 2'b11, 32'h0F0F_F0F0, "R6 write two cycles after read");
    do_op(0, 0, 19'd20, 2'b11, '0, "R9 read after delayed write");

    repeat (6) @(negedge clk_i);
    check_idle("R8 final idle");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule